// File: doc/BRIEF.md
# Bus Clock Stop Gate

This block derives a group of bus clocks from a fast core clock by even division and lets an active-low, asynchronous stop request halt them without ever cutting a pulse short. Each gated output has its own enable bit. A separate free-running output ignores the stop request entirely. A mode input decides whether the stop request is honoured at all: it acts only in low-power mode. All gating is done in synchronous logic on the divided waveform, so no clock net is gated.

The stop request passes through a two-flop synchronizer. A small state machine makes its decisions only at the end of each divided period, when every output is low. It has three states:

- ST_RUN: the gated outputs toggle.
- ST_PARK: the gated outputs are held low.
- ST_MINRUN: the outputs toggle for a guaranteed minimum number of periods after a restart.

The transitions are:

- RUN to PARK, when a qualified stop is present at a period boundary.
- PARK to MINRUN, when the qualified stop is gone at a boundary.
- MINRUN to RUN, after MIN_RUN periods if no stop is present.
- MINRUN to PARK, after MIN_RUN periods if a stop is present.

Reset leaves the machine in ST_RUN.

Top module: `busclk_stop_gate`

## Requirements
- R1: With `desktop_mode`=0, driving `stop_n` low stops all gated outputs. At most one more rising edge appears on a gated output within DIV+3 core cycles of the change, and none after that.
- R2: A stopped gated output sits at logic low. Every high pulse on any output lasts exactly DIV/2 core cycles; no shortened high or low phase occurs.
- R3: After `stop_n` returns high, the first rising edge on an enabled gated output appears within DIV+3 core cycles, and that pulse is full width.
- R4: After a restart, the gated outputs produce exactly MIN_RUN pulses before a stop can take effect again, even if `stop_n` is driven low right away.
- R5: `clk_free` keeps toggling at the core rate divided by DIV whatever the values of `stop_n` and `desktop_mode`.
- R6: With `desktop_mode`=1, `stop_n` has no effect on the gated outputs.
- R7: `out_en[i]`=0 holds `clk_out[i]` low. Enable bits and the stop decision are taken only at a period boundary, so outputs rise only at the start of a period.
- R8: `free_en`=0 holds `clk_free` low.
- R9: While `rst_n` is low, all outputs are low. When running, each enabled output gives DIV/2 core cycles high, then DIV/2 low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| desktop_mode | input | 1 | 1 ignores stop requests, 0 honours them |
| out_en | input | N_OUT | Per-output enable for the gated clocks |
| free_en | input | 1 | Enable for the free-running clock |
| clk_out | output | N_OUT | Gated divided clocks |
| clk_free | output | 1 | Free-running divided clock |

## Verification
Any fault in the phase counter or the output registers shows up as a pulse whose width differs from DIV/2 cycles, or as an edge off the period boundary. This is visible at the ports within one divided period. A wrong state-machine state shows as pulses after a stop, missing pulses after a release, or a minimum-run count other than MIN_RUN; this is visible within a few periods of the request changing. A synchronizer fault shifts the stop and restart latencies outside the DIV+3 cycle window.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PARK   = 2'd1,
        ST_MINRUN = 2'd2
    } gate_st_e;
endpackage

// File: rtl/busclk_sync.sv
module busclk_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/busclk_divider.sv
module busclk_divider #(
    parameter int DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [$clog2(DIV)-1:0] ph_q,
    output logic                   tick,
    output logic                   hi_nxt
);
    localparam int PH_W = $clog2(DIV);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] HALF_PH = PH_W'(DIV / 2);

    logic [PH_W-1:0] ph_nxt;

    always_comb begin
        tick   = (ph_q == LAST_PH);
        ph_nxt = tick ? '0 : ph_q + 1'b1;
        hi_nxt = (ph_nxt < HALF_PH);
    end

    // reset to last phase so the first edge after reset opens a full period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= LAST_PH;
        else        ph_q <= ph_nxt;
    end
endmodule

// File: rtl/busclk_gate_fsm.sv
module busclk_gate_fsm
    import busclk_pkg::*;
#(
    parameter int MIN_RUN = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          stop_act,
    output gate_st_e                      st_q,
    output logic [$clog2(MIN_RUN+1)-1:0]  cnt_q,
    output logic                          gate_nxt
);
    localparam int CNT_W = $clog2(MIN_RUN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_RUN - 1);

    gate_st_e        st_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (tick) begin
            unique case (st_q)
                ST_RUN: begin
                    if (stop_act) st_nxt = ST_PARK;
                end
                ST_PARK: begin
                    if (!stop_act) begin
                        st_nxt  = ST_MINRUN;
                        cnt_nxt = '0;
                    end
                end
                ST_MINRUN: begin
                    if (cnt_q == LAST_CNT) st_nxt = stop_act ? ST_PARK : ST_RUN;
                    else                   cnt_nxt = cnt_q + 1'b1;
                end
                default: st_nxt = ST_PARK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    always_comb begin
        gate_nxt = (st_nxt != ST_PARK);
    end
endmodule

// File: rtl/busclk_stop_gate.sv
module busclk_stop_gate
    import busclk_pkg::*;
#(
    parameter int N_OUT   = 5,
    parameter int DIV     = 4,
    parameter int MIN_RUN = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n,
    input  logic             desktop_mode,
    input  logic [N_OUT-1:0] out_en,
    input  logic             free_en,
    output logic [N_OUT-1:0] clk_out,
    output logic             clk_free
);
    localparam int PH_W  = $clog2(DIV);
    localparam int CNT_W = $clog2(MIN_RUN + 1);

    logic             stop_sync_n;
    logic [PH_W-1:0]  ph_q;
    logic             tick;
    logic             hi_nxt;
    logic             stop_act;
    gate_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             gate_nxt;
    logic [N_OUT-1:0] en_q;
    logic [N_OUT-1:0] en_nxt;
    logic             free_en_q;
    logic             free_en_nxt;
    logic [N_OUT-1:0] clk_out_q;
    logic             clk_free_q;

    busclk_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (stop_n),
        .q_sync  (stop_sync_n)
    );

    busclk_divider #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_q   (ph_q),
        .tick   (tick),
        .hi_nxt (hi_nxt)
    );

    assign stop_act = !stop_sync_n && !desktop_mode;

    busclk_gate_fsm #(.MIN_RUN(MIN_RUN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .stop_act (stop_act),
        .st_q     (st_q),
        .cnt_q    (cnt_q),
        .gate_nxt (gate_nxt)
    );

    // enables are taken only at the period boundary, while every output is low
    always_comb begin
        en_nxt      = tick ? out_en  : en_q;
        free_en_nxt = tick ? free_en : free_en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            free_en_q <= 1'b0;
        end else begin
            en_q      <= en_nxt;
            free_en_q <= free_en_nxt;
        end
    end

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clk_out_q[gi] <= 1'b0;
            else        clk_out_q[gi] <= hi_nxt & gate_nxt & en_nxt[gi];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_free_q <= 1'b0;
        else        clk_free_q <= hi_nxt & free_en_nxt;
    end

    assign clk_out  = clk_out_q;
    assign clk_free = clk_free_q;
endmodule

// File: rtl/busclk_stop_gate_chk.sv
module busclk_stop_gate_chk
    import busclk_pkg::*;
#(
    parameter int N_OUT   = 5,
    parameter int DIV     = 4,
    parameter int MIN_RUN = 10
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          desktop_mode,
    input logic [$clog2(DIV)-1:0]        ph_q,
    input gate_st_e                      st_q,
    input logic [$clog2(MIN_RUN+1)-1:0]  cnt_q,
    input logic [N_OUT-1:0]              clk_out
);
    localparam int PH_W  = $clog2(DIV);
    localparam int CNT_W = $clog2(MIN_RUN + 1);
    localparam logic [PH_W-1:0]  HALF_PH  = PH_W'(DIV / 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_RUN - 1);

    // R2: outputs fall only at the midpoint of a period
    a_r2_fall_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(clk_out) & ~clk_out)) |-> (ph_q == HALF_PH));

    // R3: outputs rise only at the start of a period
    a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(clk_out) & clk_out)) |-> (ph_q == '0));

    // R7: the gate state only changes at a period boundary
    a_r7_state_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> (ph_q == '0));

    // R6: in desktop mode the machine never parks
    a_r6_desktop_no_park: assert property (@(posedge clk) disable iff (!rst_n)
        (desktop_mode && st_q != ST_PARK) |=> (st_q != ST_PARK));

    // R4: the minimum-run counter stays inside its window
    a_r4_minrun_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MINRUN) |-> (cnt_q <= LAST_CNT));
endmodule

bind busclk_stop_gate busclk_stop_gate_chk #(
    .N_OUT(N_OUT), .DIV(DIV), .MIN_RUN(MIN_RUN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .desktop_mode (desktop_mode),
    .ph_q         (ph_q),
    .st_q         (st_q),
    .cnt_q        (cnt_q),
    .clk_out      (clk_out)
);

// File: tb/sim_busclk_stop_gate.sv
module sim_busclk_stop_gate;
    localparam int N   = 4;
    localparam int DIV = 4;
    localparam int HALF = DIV / 2;
    localparam int MINR = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic         desktop_mode = 1'b0;
    logic [N-1:0] out_en = '1;
    logic         free_en = 1'b1;
    logic [N-1:0] clk_out;
    logic         clk_free;

    int n_chk = 0;
    int n_bad = 0;
    int rises [N+1];
    int hi_len [N+1];
    int lo_len [N+1];
    bit seen_hi [N+1];
    bit prev [N+1];
    int width_bad = 0;
    int cyc = 0;

    // table: {desktop_mode, stop_n, out_en[3:0], expected toggling mask[3:0]}
    localparam logic [9:0] TBL [8] = '{
        {1'b0, 1'b1, 4'hF, 4'hF},
        {1'b0, 1'b0, 4'hF, 4'h0},
        {1'b1, 1'b0, 4'hF, 4'hF},
        {1'b0, 1'b1, 4'h5, 4'h5},
        {1'b0, 1'b0, 4'hA, 4'h0},
        {1'b1, 1'b1, 4'h3, 4'h3},
        {1'b0, 1'b1, 4'h0, 4'h0},
        {1'b1, 1'b0, 4'hC, 4'hC}
    };

    busclk_stop_gate #(.N_OUT(N), .DIV(DIV), .MIN_RUN(MINR)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_n       (stop_n),
        .desktop_mode (desktop_mode),
        .out_en       (out_en),
        .free_en      (free_en),
        .clk_out      (clk_out),
        .clk_free     (clk_free)
    );

    always #5 clk = ~clk;

    // edge counting and pulse-width monitor for R2, R3 and R9
    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i <= N; i++) begin
            automatic bit cur = (i < N) ? clk_out[i] : clk_free;
            if (!rst_n) begin
                hi_len[i] = 0; lo_len[i] = 0; seen_hi[i] = 0;
            end else if (cur) begin
                if (!prev[i]) begin
                    rises[i]++;
                    if (seen_hi[i] && lo_len[i] < HALF) width_bad++;
                    hi_len[i] = 0;
                end
                hi_len[i]++;
            end else begin
                if (prev[i]) begin
                    if (hi_len[i] != HALF) width_bad++;
                    seen_hi[i] = 1;
                    lo_len[i] = 0;
                end
                lo_len[i]++;
            end
            prev[i] = cur;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic clr();
        for (int i = 0; i <= N; i++) rises[i] = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        while (cyc < 100000) @(negedge clk);
        check(0, "watchdog", cyc, 100000);
        finish_run();
    end

    initial begin
        // R9: all outputs low during reset
        step(6);
        check(clk_out == '0, "R9 reset clk_out", int'(clk_out), 0);
        check(clk_free == 1'b0, "R9 reset clk_free", int'(clk_free), 0);
        rst_n = 1'b1;
        step(12 * DIV);

        // table walk: R1, R5, R6, R7, R9
        for (int k = 0; k < 8; k++) begin
            desktop_mode = TBL[k][9];
            stop_n       = TBL[k][8];
            out_en       = TBL[k][7:4];
            step(12 * DIV);
            clr();
            step(4 * DIV);
            for (int i = 0; i < N; i++) begin
                automatic int exp = TBL[k][i] ? 4 : 0;
                check(rises[i] == exp, "R1/R6/R7/R9 gated edges", rises[i], exp);
            end
            check(rises[N] == 4, "R5 free edges", rises[N], 4);
        end

        // R1: off latency in mobile mode from a long run
        desktop_mode = 1'b0; out_en = '1; stop_n = 1'b1;
        step(20 * DIV);
        clr();
        stop_n = 1'b0;
        step(DIV + 3);
        check(rises[0] <= 1, "R1 edges before stop", rises[0], 1);
        clr();
        step(3 * DIV);
        check(rises[0] == 0, "R1 edges after stop", rises[0], 0);
        check(clk_out == '0, "R1 parked low", int'(clk_out), 0);

        // R3: on latency, then R4 minimum run with stop reasserted at once
        step(4 * DIV);
        clr();
        stop_n = 1'b1;
        step(DIV + 3);
        check(rises[0] >= 1, "R3 restart edge", rises[0], 1);
        stop_n = 1'b0;
        step(20 * DIV);
        check(rises[0] == MINR, "R4 minimum run", rises[0], MINR);

        // R8: free output disabled
        stop_n = 1'b1; free_en = 1'b0;
        step(2 * DIV);
        clr();
        step(4 * DIV);
        check(rises[N] == 0, "R8 free disabled edges", rises[N], 0);
        check(clk_free == 1'b0, "R8 free disabled level", int'(clk_free), 0);

        // R2 and R3: no short high or low phase anywhere in the run
        check(width_bad == 0, "R2/R3 pulse widths", width_bad, 0);
        finish_run();
    end
endmodule